// File: doc/BRIEF.md
# LCD Panel Refresh Sequencer

The sequencer keeps a character-cell style graphics LCD controller supplied with bytes. It reads a display buffer one word at a time, starting at word 0, and sends each byte to the panel over a parallel write-only bus. Each buffer word is nine bits wide. The upper bit chooses whether the byte is a controller command or pixel data. The lower eight bits are the byte itself. The buffer begins with a short run of controller instructions. After them come `PAGES` pages of `PAGE_BYTES` pixel bytes, and each pixel byte covers eight vertical dots.

The panel's enable strobe is slow compared with the system clock. A free-running divider therefore splits time into phases of `PHASE_CYC` clocks. With the defaults (50 clocks at 250 MHz) each phase lasts 200 ns. One byte takes three phases:

- A hold/fetch phase. The previous byte stays on the bus while the next word is read.
- A setup phase. The new byte and select level are driven and enable is low.
- A high phase. Enable is asserted.

When the last pixel byte has gone out, the scan does not repeat the whole start-up sequence. It jumps back to a chosen loop-start word near the end of the instruction run, which is typically a page-address command. It then repeats from there indefinitely, the way a raster refresh does.

Top module: `lcd_scan_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `buf_addr` to 0, `lcd_en` low, `lcd_db` to 0 and `lcd_rs` low.
- R2: `lcd_rw` is low at all times, so the panel only ever receives writes.
- R3: `lcd_en` stays high for exactly `PHASE_CYC` clocks per byte. Between pulses, and from reset to the first pulse, it stays low for exactly 2·`PHASE_CYC` clocks.
- R4: `lcd_db` and `lcd_rs` stay constant for at least `PHASE_CYC` clocks before `lcd_en` rises, during the whole high phase, and for `PHASE_CYC` clocks after `lcd_en` falls.
- R5: The buffer is read with one clock of latency. For each strobe, `lcd_db` equals bits 7:0 of the word at the address being sent, and `lcd_rs` equals bit 8 of that word (1 = pixel data, 0 = command).
- R6: `buf_addr` starts at 0 and advances by one in the clock after `lcd_en` falls. It stays unchanged at all other times.
- R7: After the last word, `INIT_LEN + PAGES*PAGE_BYTES - 1`, the next address is `LOOP_START` rather than 0. `buf_addr` never exceeds that last word.
- R8: A reset applied in the middle of a scan restarts the sequence exactly as it runs after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| buf_addr | output | AW | Display buffer read address |
| buf_word | input | 9 | Buffer read data, valid one clock after the address; bit 8 = data flag |
| lcd_en | output | 1 | Panel enable strobe |
| lcd_rs | output | 1 | Register select: 1 data, 0 command |
| lcd_rw | output | 1 | Read/write select, held at write (0) |
| lcd_db | output | 8 | Panel data bus |

## Verification
Some rules are checked on every cycle. These are the strobe widths, the bus stability windows around each enable pulse, the address stepping only on the falling edge of enable, the wrap from the last word to the loop-start word, and the constant write level. Other behaviour depends on buffer contents and absolute cycle position, so only the bench's reference model can show it. That covers whether each byte and select level really come from the word at the current address, whether the first pulse after reset lands in the right cycle, and whether a reset in mid-pulse restarts the scan from word 0.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    // Three phases make up the transfer of one byte.
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // previous byte held on the bus, next word fetched
        ST_SETUP = 2'd1,   // new byte driven, strobe low
        ST_HIGH  = 2'd2    // strobe high
    } scan_state_e;

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
    parameter int PHASE_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    output logic phase_end
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(PHASE_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == LAST_CNT) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_end = (r_q.cnt == LAST_CNT);
endmodule

// File: rtl/lcd_addr_gen.sv
module lcd_addr_gen #(
    parameter int AW         = 11,
    parameter int LAST_WORD  = 1063,
    parameter int LOOP_START = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST_A = AW'(LAST_WORD);
    localparam logic [AW-1:0] LOOP_A = AW'(LOOP_START);

    typedef struct packed {
        logic [AW-1:0] addr;
    } ag_t;

    ag_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (step) begin
            if (r_q.addr == LAST_A) begin
                r_d.addr = LOOP_A;
            end else begin
                r_d.addr = r_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr = r_q.addr;
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int INIT_LEN   = 8,
    parameter int LOOP_START = 6,
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 132,
    parameter int PHASE_CYC  = 50,
    parameter int AW         = $clog2(INIT_LEN + PAGES * PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] buf_addr,
    input  logic [8:0]    buf_word,
    output logic          lcd_en,
    output logic          lcd_rs,
    output logic          lcd_rw,
    output logic [7:0]    lcd_db
);
    localparam int WORDS     = INIT_LEN + PAGES * PAGE_BYTES;
    localparam int LAST_WORD = WORDS - 1;

    typedef struct packed {
        scan_state_e st;
        logic        en;
        logic        rs;
        logic [7:0]  db;
    } seq_t;

    seq_t r_q, r_d;
    logic phase_end;
    logic addr_step;

    lcd_phase_timer #(
        .PHASE_CYC (PHASE_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .phase_end (phase_end)
    );

    // The address moves on as the strobe falls. The following hold
    // phase hides the buffer read latency.
    assign addr_step = (r_q.st == ST_HIGH) && phase_end;

    lcd_addr_gen #(
        .AW         (AW),
        .LAST_WORD  (LAST_WORD),
        .LOOP_START (LOOP_START)
    ) u_addr (
        .clk  (clk),
        .rst  (rst),
        .step (addr_step),
        .addr (buf_addr)
    );

    always_comb begin
        r_d = r_q;
        if (phase_end) begin
            case (r_q.st)
                ST_HOLD: begin
                    r_d.rs = buf_word[8];
                    r_d.db = buf_word[7:0];
                    r_d.st = ST_SETUP;
                end
                ST_SETUP: begin
                    r_d.en = 1'b1;
                    r_d.st = ST_HIGH;
                end
                ST_HIGH: begin
                    r_d.en = 1'b0;
                    r_d.st = ST_HOLD;
                end
                default: begin
                    r_d.en = 1'b0;
                    r_d.st = ST_HOLD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= ST_HOLD;
            r_q.en <= 1'b0;
            r_q.rs <= 1'b0;
            r_q.db <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lcd_en = r_q.en;
    assign lcd_rs = r_q.rs;
    assign lcd_db = r_q.db;
    assign lcd_rw = 1'b0;
endmodule

// File: rtl/lcd_scan_seq_chk.sv
module lcd_scan_seq_chk #(
    parameter int INIT_LEN   = 8,
    parameter int LOOP_START = 6,
    parameter int PAGES      = 8,
    parameter int PAGE_BYTES = 132,
    parameter int PHASE_CYC  = 50,
    parameter int AW         = 11
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] buf_addr,
    input logic          lcd_en,
    input logic          lcd_rs,
    input logic          lcd_rw,
    input logic [7:0]    lcd_db
);
    localparam int LAST_WORD = INIT_LEN + PAGES * PAGE_BYTES - 1;

    int unsigned hi_cnt_q;
    int unsigned lo_cnt_q;
    int unsigned age_q;
    logic [8:0]  bus_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt_q   <= 0;
            lo_cnt_q   <= 0;
            age_q      <= 0;
            bus_prev_q <= '0;
        end else begin
            hi_cnt_q   <= lcd_en ? hi_cnt_q + 1 : 0;
            lo_cnt_q   <= lcd_en ? 0 : lo_cnt_q + 1;
            bus_prev_q <= {lcd_rs, lcd_db};
            if ({lcd_rs, lcd_db} != bus_prev_q) begin
                age_q <= 0;
            end else if (age_q < 32'h4000_0000) begin
                age_q <= age_q + 1;
            end
        end
    end

    p_write_only_r2: assert property (@(posedge clk) disable iff (rst)
        lcd_rw == 1'b0);

    p_high_width_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |-> hi_cnt_q == PHASE_CYC);

    p_low_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_en) |-> lo_cnt_q == 2 * PHASE_CYC);

    p_setup_time_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_en) |-> age_q >= PHASE_CYC - 1);

    p_stable_high_r4: assert property (@(posedge clk) disable iff (rst)
        (lcd_en || $fell(lcd_en)) |-> $stable({lcd_rs, lcd_db}));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(lcd_en) && int'($past(buf_addr)) != LAST_WORD)
            |-> int'(buf_addr) == int'($past(buf_addr)) + 1);

    p_addr_still_r6: assert property (@(posedge clk) disable iff (rst)
        !$fell(lcd_en) |-> $stable(buf_addr));

    p_addr_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(lcd_en) && int'($past(buf_addr)) == LAST_WORD)
            |-> int'(buf_addr) == LOOP_START);

    p_addr_range_r7: assert property (@(posedge clk) disable iff (rst)
        int'(buf_addr) <= LAST_WORD);
endmodule

bind lcd_scan_seq lcd_scan_seq_chk #(
    .INIT_LEN   (INIT_LEN),
    .LOOP_START (LOOP_START),
    .PAGES      (PAGES),
    .PAGE_BYTES (PAGE_BYTES),
    .PHASE_CYC  (PHASE_CYC),
    .AW         (AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .buf_addr (buf_addr),
    .lcd_en   (lcd_en),
    .lcd_rs   (lcd_rs),
    .lcd_rw   (lcd_rw),
    .lcd_db   (lcd_db)
);

// File: tb/lcd_scan_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_scan_seq_tb_top;
    localparam int INIT_LEN   = 3;
    localparam int LOOP_START = 1;
    localparam int PAGES      = 2;
    localparam int PAGE_BYTES = 5;
    localparam int PHASE_CYC  = 2;
    localparam int WORDS      = INIT_LEN + PAGES * PAGE_BYTES;
    localparam int AW         = $clog2(WORDS);
    localparam int SLOT       = 3 * PHASE_CYC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] buf_addr;
    logic [8:0]    buf_word;
    logic          lcd_en, lcd_rs, lcd_rw;
    logic [7:0]    lcd_db;

    int total = 0;
    int bad   = 0;
    int t     = 0;
    bit armed = 0;
    bit second_run = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    lcd_scan_seq #(
        .INIT_LEN   (INIT_LEN),
        .LOOP_START (LOOP_START),
        .PAGES      (PAGES),
        .PAGE_BYTES (PAGE_BYTES),
        .PHASE_CYC  (PHASE_CYC),
        .AW         (AW)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .buf_addr (buf_addr),
        .buf_word (buf_word),
        .lcd_en   (lcd_en),
        .lcd_rs   (lcd_rs),
        .lcd_rw   (lcd_rw),
        .lcd_db   (lcd_db)
    );

    // Buffer contents: commands first (flag 0), pixel bytes after (flag 1).
    function automatic logic [8:0] word_at(int i);
        logic [7:0] b;
        b = 8'((i * 37 + 11) % 256);
        return {(i >= INIT_LEN) ? 1'b1 : 1'b0, b};
    endfunction

    // Buffer model with a one-clock synchronous read.
    always @(posedge clk) buf_word <= word_at(int'(buf_addr));

    // Address of byte slot n, counting from the last reset.
    function automatic int seq_addr(int n);
        if (n < WORDS) return n;
        return LOOP_START + ((n - WORDS) % (WORDS - LOOP_START));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            t <= 0;
            armed <= 1;
        end else begin
            t <= t + 1;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s t=%0d actual=%0d expected=%0d", req, what, t, act, exp);
        end
    endtask

    // Reference model, compared on every falling edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            int slot, ph, e_addr, e_en, e_word;
            string pre;
            slot   = t / SLOT;
            ph     = (t % SLOT) / PHASE_CYC;
            e_addr = seq_addr(slot);
            e_en   = (ph == 2) ? 1 : 0;
            if (ph == 0) e_word = (slot == 0) ? 0 : int'(word_at(seq_addr(slot - 1)));
            else         e_word = int'(word_at(e_addr));
            pre = second_run ? "R8 " : "";
            if (t == 0) begin
                check({pre, "R1"}, "addr", int'(buf_addr), 0);
                check({pre, "R1"}, "en", int'(lcd_en), 0);
                check({pre, "R1"}, "db", int'(lcd_db), 0);
                check({pre, "R1"}, "rs", int'(lcd_rs), 0);
            end else begin
                check({pre, "R2"}, "rw", int'(lcd_rw), 0);
                check({pre, "R3"}, "en", int'(lcd_en), e_en);
                check({pre, "R4 R5"}, "db", int'(lcd_db), e_word % 256);
                check({pre, "R4 R5"}, "rs", int'(lcd_rs), e_word / 256);
                check({pre, (slot >= WORDS) ? "R7" : "R6"}, "addr", int'(buf_addr), e_addr);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // Three full refresh passes, including the wrap to the loop-start word.
        repeat (SLOT * (3 * WORDS) + 3) @(posedge clk);
        // Reset during an enable-high phase.
        wait (lcd_en == 1'b1);
        @(posedge clk);
        #1 rst = 1'b1;
        second_run = 1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (SLOT * (WORDS + 4)) @(posedge clk);
        #1 done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog t=%0d actual=running expected=finished", t);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule